// File: doc/BRIEF.md
# Polyphase Parallel-Output NCO

This block is a numerically controlled oscillator that delivers several consecutive samples of a complex sinusoid on every clock. A slow fabric clock can then feed a data converter that runs a whole number of times faster. For example, four lanes at 250 MHz carry a 1 GS/s stream. The tuning word states the phase step per output sample at the full aggregate rate.

Each lane keeps its own phase register. Within one clock, lane i holds the phase of sample i of that clock's group. Across clocks, every lane moves on by LANES times the tuning word. Each phase is quantised to its top bits and looked up in a quarter-wave table, which is built when the design is elaborated. Quadrant folding in the lookup yields a signed 16-bit cosine and sine per lane. The lanes are packed onto two wide buses and share one valid flag.

Top module: `poly_nco`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and every bit of `cos_bus` and `sin_bus` is 0. The reset acts asynchronously.
- R2: After `rst_n` is released, `out_valid` first reads 1 after the third rising clock edge. It then stays 1 until the next reset.
- R3: Lane i occupies bits [16i+15:16i] of both buses, and lane 0 is the earliest sample. Consider the k-th valid output word after reset, counted from 0, with a constant tuning word F. Lane i then carries the sample at phase F·(LANES·k+i) mod 2^32.
- R4: Each cosine lane equals round(32767·cos(2π(q+0.5)/2^(LUT_AW+2))) to within ±2 LSB. Here q is the top LUT_AW+2 bits of that lane's phase, which are bits 31:22 at the default LUT_AW = 8.
- R5: Each sine lane equals round(32767·sin(2π(q+0.5)/2^(LUT_AW+2))) to within ±2 LSB, with q as in R4.
- R6: Every clock, each lane's phase advances by F shifted left by log2(LANES) bits, modulo 2^32. A tuning word of 0 therefore holds every lane at the same, unchanging output.
- R7: The tuning word is sampled on every rising edge, and a new word applies to all lanes on the same edge. Lane 0's new phase is the previous group's last-lane phase plus the new word. Lane i adds i further steps of the new word.
- R8: On every valid output, each lane's cos²+sin² lies within 2·32767 of 32767². The value −32768 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | 32 | Phase step per output sample at the aggregate rate |
| out_valid | output | 1 | The buses carry valid samples |
| cos_bus | output | 16·LANES | Packed signed cosine samples, lane 0 in the low bits |
| sin_bus | output | 16·LANES | Packed signed sine samples, lane 0 in the low bits |

## Verification
- **Slow tone (0x01111111):** the lanes stay close together on the circle, so a wrong lane offset or a swapped lane slice shows up as a small phase error in one lane.
- **Quarter-turn word (0x40000000):** every sample lands in a different quadrant, which isolates errors in the quadrant mirroring and the sign handling of cosine and sine.
- **Near-full-scale word (0xE0000000):** the phase wraps every sample, which exposes a missing modulo or a wrong shift of the group step.
- **Retuning every few clocks and a zero word:** these show whether retuning keeps the phase continuous and whether all lanes hold still together.

// File: rtl/poly_nco_pkg.sv
package poly_nco_pkg;
  localparam int PHASE_W  = 32;
  localparam int SAMPLE_W = 16;

  typedef logic [PHASE_W-1:0]         phase_t;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
endpackage

// File: rtl/nco_phase_lanes.sv
module nco_phase_lanes
  import poly_nco_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  phase_t               ftw,
  output phase_t [LANES-1:0]   phase_o,
  output logic                 live_o
);
  localparam int SHIFT = $clog2(LANES);

  if ((1 << SHIFT) != LANES) begin : g_bad_lanes
    $error("LANES must be a power of two");
  end

  phase_t [LANES-1:0] ph_q, ph_nx;
  logic               live_q;

  // Next phases: a group continues from the last lane of the previous group.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (live_q) ph_nx[i] = ph_q[LANES-1] + phase_t'(i + 1) * ftw;
      else        ph_nx[i] = phase_t'(i) * ftw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      live_q <= 1'b0;
    end else begin
      ph_q   <= ph_nx;
      live_q <= 1'b1;
    end
  end

  assign phase_o = ph_q;
  assign live_o  = live_q;

  // R6: with a steady tuning word, lane 0 steps by LANES*ftw per clock
  a_r6_group_step: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && (ftw == $past(ftw)) |=> ph_q[0] == $past(ph_q[0]) + ($past(ftw) << SHIFT));

  if (LANES > 1) begin : g_span_chk
    // R7: all lanes of one group are spaced by the word sampled on the same edge
    a_r7_lane_span: assert property (@(posedge clk) disable iff (!rst_n)
      live_q |-> (ph_q[LANES-1] - ph_q[0]) == phase_t'(LANES - 1) * $past(ftw));
  end
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos
  import poly_nco_pkg::*;
#(
  parameter int LUT_AW = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  phase_t  phase_i,
  output sample_t cos_o,
  output sample_t sin_o
);
  localparam int IDX_W   = LUT_AW + 2;
  localparam int ENTRIES = 1 << LUT_AW;
  localparam int PEAK    = (1 << (SAMPLE_W - 1)) - 1;

  typedef logic [SAMPLE_W-1:0] mag_t;
  typedef logic [IDX_W-1:0]    idx_t;

  function automatic logic [ENTRIES-1:0][SAMPLE_W-1:0] build_table();
    logic [ENTRIES-1:0][SAMPLE_W-1:0] t;
    for (int k = 0; k < ENTRIES; k++) begin
      real ang;
      ang  = 6.283185307179586 * (real'(k) + 0.5) / real'(4 * ENTRIES);
      t[k] = SAMPLE_W'($rtoi(real'(PEAK) * $sin(ang) + 0.5));
    end
    return t;
  endfunction

  localparam logic [ENTRIES-1:0][SAMPLE_W-1:0] QTAB = build_table();

  idx_t    idx_s, idx_c;
  mag_t    mag_s_nx, mag_c_nx, mag_s_q, mag_c_q;
  logic    neg_s_nx, neg_c_nx, neg_s_q, neg_c_q;
  sample_t cos_nx, sin_nx, cos_q, sin_q;

  // Stage 1: quadrant fold; cosine is sine advanced by a quarter turn
  always_comb begin
    idx_s    = phase_i[PHASE_W-1 -: IDX_W];
    idx_c    = idx_s + idx_t'(ENTRIES);
    mag_s_nx = QTAB[idx_s[LUT_AW] ? ~idx_s[LUT_AW-1:0] : idx_s[LUT_AW-1:0]];
    mag_c_nx = QTAB[idx_c[LUT_AW] ? ~idx_c[LUT_AW-1:0] : idx_c[LUT_AW-1:0]];
    neg_s_nx = idx_s[IDX_W-1];
    neg_c_nx = idx_c[IDX_W-1];
  end

  // Stage 2: apply the sign of the lower half-turn
  always_comb begin
    sin_nx = neg_s_q ? -sample_t'(mag_s_q) : sample_t'(mag_s_q);
    cos_nx = neg_c_q ? -sample_t'(mag_c_q) : sample_t'(mag_c_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_s_q <= '0;
      mag_c_q <= '0;
      neg_s_q <= 1'b0;
      neg_c_q <= 1'b0;
      sin_q   <= '0;
      cos_q   <= '0;
    end else begin
      mag_s_q <= mag_s_nx;
      mag_c_q <= mag_c_nx;
      neg_s_q <= neg_s_nx;
      neg_c_q <= neg_c_nx;
      sin_q   <= sin_nx;
      cos_q   <= cos_nx;
    end
  end

  assign cos_o = cos_q;
  assign sin_o = sin_q;
endmodule

// File: rtl/poly_nco.sv
module poly_nco
  import poly_nco_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LUT_AW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PHASE_W-1:0]          tune_word,
  output logic                        out_valid,
  output logic [LANES*SAMPLE_W-1:0]   cos_bus,
  output logic [LANES*SAMPLE_W-1:0]   sin_bus
);
  localparam int LOOKUP_STAGES = 2;
  localparam int PEAK          = (1 << (SAMPLE_W - 1)) - 1;
  localparam int PWR_W         = 2 * SAMPLE_W + 2;

  phase_t [LANES-1:0]             lane_phase;
  logic                           live;
  sample_t                        lane_cos [LANES];
  sample_t                        lane_sin [LANES];
  logic [LOOKUP_STAGES-1:0]       vld_q, vld_nx;

  nco_phase_lanes #(.LANES(LANES)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .ftw     (tune_word),
    .phase_o (lane_phase),
    .live_o  (live)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    nco_sincos #(.LUT_AW(LUT_AW)) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase_i (lane_phase[i]),
      .cos_o   (lane_cos[i]),
      .sin_o   (lane_sin[i])
    );
    assign cos_bus[i*SAMPLE_W +: SAMPLE_W] = lane_cos[i];
    assign sin_bus[i*SAMPLE_W +: SAMPLE_W] = lane_sin[i];

    logic signed [PWR_W-1:0] ce, se, pwr;
    assign ce  = PWR_W'(lane_cos[i]);
    assign se  = PWR_W'(lane_sin[i]);
    assign pwr = ce * ce + se * se;

    // R8: each valid lane sits on the unit circle within quantisation error
    a_r8_unit_circle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pwr > PWR_W'(PEAK * PEAK - 2 * PEAK)) &&
                    (pwr < PWR_W'(PEAK * PEAK + 2 * PEAK)));
    // R8: the most negative code never appears
    a_r8_no_neg_full: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (lane_cos[i] != sample_t'(-PEAK - 1)) &&
                    (lane_sin[i] != sample_t'(-PEAK - 1)));
  end

  // Valid follows the phase register through the lookup stages
  always_comb vld_nx = {vld_q[LOOKUP_STAGES-2:0], live};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_nx;
  end

  assign out_valid = vld_q[LOOKUP_STAGES-1];

  // R2: valid rises exactly two clocks after the phase registers first load
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(live, 2) && !$past(live, 3));
  // R2: once valid, stays valid until reset
  a_r2_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);
endmodule

// File: tb/poly_nco_test.sv
module poly_nco_test;
  localparam int  CLK_NS = 4;
  localparam int  LANES  = 4;
  localparam int  LUT_AW = 8;
  localparam int  IDX_W  = LUT_AW + 2;
  localparam real TWO_PI = 6.283185307179586;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [31:0]           tune_word = '0;
  logic                  out_valid;
  logic [LANES*16-1:0]   cos_bus, sin_bus;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  poly_nco #(.LANES(LANES), .LUT_AW(LUT_AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tune_word (tune_word),
    .out_valid (out_valid),
    .cos_bus   (cos_bus),
    .sin_bus   (sin_bus)
  );

  always #(CLK_NS / 2) clk = ~clk;

  // Reference phases from R3/R7: a new group continues from the last sample
  logic [31:0] last_ph;
  bit          started;
  logic [31:0] m1 [LANES];
  logic [31:0] m2 [LANES];
  logic [31:0] m3 [LANES];
  bit          v1, v2, v3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      last_ph <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++)
        m1[i] <= started ? last_ph + 32'(i + 1) * tune_word : 32'(i) * tune_word;
      last_ph <= started ? last_ph + 32'(LANES) * tune_word : 32'(LANES - 1) * tune_word;
      started <= 1'b1;
      m2 <= m1; m3 <= m2;
      v1 <= 1'b1; v2 <= v1; v3 <= v2;
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_val(logic [31:0] ph, bit want_cos);
    int  q;
    real a, v;
    q = int'(ph >> (32 - IDX_W));
    a = TWO_PI * (real'(q) + 0.5) / real'(1 << IDX_W);
    v = 32767.0 * (want_cos ? $cos(a) : $sin(a));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic compare_lanes(string req);
    for (int i = 0; i < LANES; i++) begin
      int c_act, s_act, c_exp, s_exp;
      longint pwr;
      c_act = int'($signed(cos_bus[i*16 +: 16]));
      s_act = int'($signed(sin_bus[i*16 +: 16]));
      c_exp = model_val(m3[i], 1'b1);
      s_exp = model_val(m3[i], 1'b0);
      check((c_act - c_exp) <= 2 && (c_exp - c_act) <= 2, {req, " R4"},
            $sformatf("lane %0d cos", i), c_act, c_exp);
      check((s_act - s_exp) <= 2 && (s_exp - s_act) <= 2, {req, " R5"},
            $sformatf("lane %0d sin", i), s_act, s_exp);
      pwr = longint'(c_act) * c_act + longint'(s_act) * s_act;
      check(pwr > 64'd1073676289 - 64'd65534 && pwr < 64'd1073676289 + 64'd65534
            && c_act != -32768 && s_act != -32768, "R8",
            $sformatf("lane %0d power", i), pwr, 64'd1073676289);
    end
  endtask

  task automatic run_tone(logic [31:0] f, int cycles, string req);
    @(negedge clk) tune_word = f;
    repeat (cycles) begin
      @(negedge clk);
      check(out_valid == v3, "R2", "valid held", longint'(out_valid), longint'(v3));
      if (v3) compare_lanes(req);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tune_word = 32'h0111_1111;
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "valid in reset", longint'(out_valid), 0);
      check(cos_bus == '0 && sin_bus == '0, "R1", "buses in reset",
            longint'(cos_bus[15:0]), 0);
    end
  endtask

  task automatic t_latency();
    rst_n = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      check(out_valid == (n >= 3), "R2", $sformatf("valid after edge %0d", n),
            longint'(out_valid), longint'(n >= 3));
    end
  endtask

  task automatic t_retune();
    logic [31:0] words [4];
    words[0] = 32'h0111_1111; words[1] = 32'h2345_6789;
    words[2] = 32'h0000_0000; words[3] = 32'hF00F_0F0F;
    for (int r = 0; r < 12; r++) run_tone(words[r % 4], 3, "R7");
  endtask

  task automatic t_zero_word();
    run_tone(32'h0, 12, "R6");
    for (int i = 1; i < LANES; i++) begin
      check(cos_bus[i*16 +: 16] == cos_bus[15:0] && sin_bus[i*16 +: 16] == sin_bus[15:0],
            "R6", $sformatf("lane %0d held equal", i),
            longint'(cos_bus[i*16 +: 16]), longint'(cos_bus[15:0]));
    end
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", "valid on async reset", longint'(out_valid), 0);
    check(cos_bus == '0 && sin_bus == '0, "R1", "buses on async reset",
          longint'(sin_bus[15:0]), 0);
    @(negedge clk);
    t_latency();
    run_tone(32'h0555_5555, 10, "R3");
  endtask

  initial begin
    t_reset();
    t_latency();
    run_tone(32'h0111_1111, 40, "R3");
    run_tone(32'h4000_0000, 16, "R5");
    run_tone(32'hE000_0000, 16, "R6");
    t_retune();
    t_zero_word();
    t_mid_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule